// File: doc/BRIEF.md
# Input glitch filter

A per-pin qualifier that sits between the pad inputs of a 16-pin general-purpose port and the logic that looks for edges on those pins. Each raw pin level is brought into the system clock domain through a two-flop synchroniser. It is then either passed straight through or held back until it has stayed at its new level for a fixed number of clock cycles.

Each pin has its own filter-enable bit. When the bit is set, pulses shorter than the hold time never reach the output, and level changes that last longer than the hold time are always passed. The hold time is derived from the clock frequency and a target duration; the default is 650 ns at 100 MHz, or 65 cycles. That lies safely between the 225 ns that must be rejected and the 1075 ns that must be accepted. When the bit is clear, every change passes, including one-cycle pulses.

The configuration register that drives the enable vector is expected to reset to all ones, so every pin is filtered after reset. At reset release the qualified outputs are loaded from the synchronised pins, so downstream edge detection sees no false edge.

Top module: `pin_glitch_filter`

## Requirements
- R1: With a pin's enable bit at 1, a raw level held for at least HOLD_CYCLES clock edges (65 by default) appears on that pin's output at the (HOLD_CYCLES+2)th rising edge after the raw change, counting the first edge that samples it as edge 1.
- R2: With a pin's enable bit at 1, a raw pulse sampled on fewer than HOLD_CYCLES edges leaves that pin's output unchanged.
- R3: With a pin's enable bit at 0, every raw change, including a pulse one clock long, appears on the output at the 3rd rising edge after the raw change.
- R4: Activity on one pin never changes the output of any other pin.
- R5: While rst_ni is low all outputs are 0. After release, the outputs take the raw pin levels at the 3rd rising edge and then keep them while the raw levels stay constant, even with filtering enabled.
- R6: Setting an enable bit from 0 to 1 never changes that output. Clearing it while a change is being timed passes the synchronised level at the next edge. The output only ever takes a level the synchronised input actually held.
- R7: With filtering enabled, a return of the raw level to the output's value for even one sampled edge restarts the timing, so two sub-threshold pulses split by a one-cycle gap are both rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_raw_i | input | 16 | Raw pad levels, asynchronous to clk_i |
| filt_en_i | input | 16 | Per-pin filter enable, 1 = filtered, 0 = bypass |
| pin_qual_o | output | 16 | Qualified pin levels |

## Verification
A counter stuck or failing to restart on a pin shows at the ports within one hold window. Either a short pulse leaks through, or an accepted change comes out early, late or never, and the bench times every edge of the output to the exact clock. A fault in the priming after reset or in the bypass path shows within three edges as a wrong output level. A lane crossing between pins shows as a change on an idle pin while the sweep pulses its neighbours.

// File: rtl/gf_pkg.sv
package gf_pkg;
  // Hold time in clock cycles for a given clock frequency and target duration.
  function automatic int unsigned hold_cycles(int unsigned freq_hz, int unsigned hold_ns);
    return ((freq_hz / 1_000_000) * hold_ns) / 1000;
  endfunction
endpackage

// File: rtl/gf_sync_vec.sv
module gf_sync_vec #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gf_pin_cell.sv
module gf_pin_cell #(
  parameter int unsigned HOLD_CYCLES = 65,
  parameter int unsigned CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prime_i,
  input  logic en_i,
  input  logic sync_i,
  output logic qual_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(HOLD_CYCLES);

  logic             qual_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pass_now;

  assign pass_now = prime_i || !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pass_now) begin
      qual_q <= sync_i;
      cnt_q  <= '0;
    end else if (sync_i == qual_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == LAST) begin
      qual_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign qual_o = qual_q;

  // Independent run-length tracker for the assertions below.
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  run_q <= '0;
    else if (pass_now || sync_i == qual_q)        run_q <= '0;
    else if (run_q != SAT)                        run_q <= run_q + 1'b1;
  end

  assert_pass_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_now |=> qual_q == $past(sync_i));

  assert_only_real_levels_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(qual_q) |-> qual_q == $past(sync_i));

  assert_hold_when_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_now && sync_i == qual_q) |=> $stable(qual_q));

  assert_min_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(qual_q) && !$past(pass_now)) |-> $past(run_q) >= LAST);
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned HOLD_NS     = 650
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_raw_i,
  input  logic [NUM_PINS-1:0] filt_en_i,
  output logic [NUM_PINS-1:0] pin_qual_o
);
  localparam int unsigned HOLD_CYCLES = gf_pkg::hold_cycles(CLK_FREQ_HZ, HOLD_NS);
  localparam int unsigned CNT_W       = $clog2(HOLD_CYCLES + 1);

  logic [NUM_PINS-1:0] pin_sync;
  logic [1:0]          prime_q;
  logic                prime;

  gf_sync_vec #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_raw_i),
    .q_o    (pin_sync)
  );

  // Load outputs straight from the synchroniser for the first three edges.
  assign prime = (prime_q != 2'd3);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prime_q <= 2'd0;
    else if (prime) prime_q <= prime_q + 2'd1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gf_pin_cell #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .prime_i (prime),
      .en_i    (filt_en_i[p]),
      .sync_i  (pin_sync[p]),
      .qual_o  (pin_qual_o[p])
    );
  end

  assert_prime_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prime |=> pin_qual_o == $past(pin_sync));
endmodule

// File: tb/pin_glitch_filter_tb.sv
module pin_glitch_filter_tb_top;
  localparam int CLK_PERIOD_NS = 10;
  localparam int NP   = 16;
  localparam int HOLD = (100 * 650) / 1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] raw = '0;
  logic [NP-1:0] en  = '1;
  logic [NP-1:0] qual;
  logic [NP-1:0] base;
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 0;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  pin_glitch_filter dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_raw_i  (raw),
    .filt_en_i  (en),
    .pin_qual_o (qual)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // Pulse one pin away from base for p sampled edges; h is the effective hold (1 = bypass).
  task automatic pulse(int pin, int p, int h, string req);
    int rise = -1, fall = -1;
    bit other_bad = 0;
    logic [NP-1:0] mask = ~(NP'(1) << pin);
    raw[pin] = ~base[pin];
    for (int t = 1; t <= p + h + 8; t++) begin
      @(posedge clk); @(negedge clk);
      if (rise < 0 && qual[pin] != base[pin]) rise = t;
      if (rise >= 0 && fall < 0 && qual[pin] == base[pin]) fall = t;
      if ((qual & mask) != (base & mask)) other_bad = 1;
      if (t == p) raw[pin] = base[pin];
    end
    if (p >= h) begin
      check({req, " rise"}, 64'(rise), 64'(h + 2));
      check({req, " fall"}, 64'(fall), 64'(p + h + 2));
    end else begin
      check({req, " short pulse blocked"}, 64'(rise), 64'(-1));
    end
    check("R4 other pins idle", 64'(other_bad), 64'd0);
  endtask

  task automatic settle(logic [NP-1:0] lvl);
    raw = lvl; base = lvl;
    edges(HOLD + 6);
    check("R1 settle", 64'(qual), 64'(lvl));
  endtask

  initial begin
    // R5 reset and priming
    raw = 16'hA5C3; en = '1; base = raw;
    edges(3);
    check("R5 zero in reset", 64'(qual), 64'd0);
    rst_n = 1'b1;
    edges(2);
    check("R5 not yet loaded", 64'(qual), 64'd0);
    edges(1);
    check("R5 loaded at 3rd edge", 64'(qual), 64'h0A5C3);
    edges(HOLD + 20);
    check("R5 no spurious edge", 64'(qual), 64'h0A5C3);

    // R1/R2 sweep of pulse widths, both polarities
    settle('0);
    for (int p = 1; p <= HOLD + 2; p++) pulse(p % NP, p, HOLD, "R1/R2 low base");
    settle('1);
    for (int p = HOLD - 3; p <= HOLD + 2; p++) pulse((p * 5) % NP, p, HOLD, "R1/R2 high base");
    pulse(9, 22, HOLD, "R2 22-cycle pulse");

    // R3 bypass
    settle('0);
    en = 16'hFF7F;
    for (int p = 1; p <= 4; p++) pulse(7, p, 1, "R3 bypass");
    en = '1;

    // R6 enable 0->1 leaves output
    settle('0);
    en = 16'hFFF7; raw[3] = 1'b1; base[3] = 1'b1;
    edges(4);
    check("R6 bypassed level", 64'(qual[3]), 64'd1);
    en = '1;
    edges(HOLD + 10);
    check("R6 enable set no change", 64'(qual), 64'(base));

    // R6 clear enable mid-count
    raw[3] = 1'b0;
    edges(22);
    check("R6 still held mid-count", 64'(qual[3]), 64'd1);
    en[3] = 1'b0;
    edges(1);
    check("R6 passes on disable", 64'(qual[3]), 64'd0);
    en = '1; base[3] = 1'b0;
    edges(HOLD + 10);
    check("R6 stable after re-enable", 64'(qual), 64'(base));

    // R7 restart on one-cycle return
    settle('0);
    begin
      bit moved = 0;
      raw[5] = 1'b1;
      for (int t = 1; t <= 2 * HOLD + 20; t++) begin
        @(posedge clk); @(negedge clk);
        if (qual[5]) moved = 1;
        if (t == HOLD - 5) raw[5] = 1'b0;
        if (t == HOLD - 4) raw[5] = 1'b1;
        if (t == 2 * HOLD - 9) raw[5] = 1'b0;
      end
      check("R7 split pulse rejected", 64'(moved), 64'd0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule